// File: doc/BRIEF.md
# Effective Address Generator

This unit turns an addressing-mode code, the one or two operand bytes of an instruction, the two index registers and the address of the following instruction into a 16-bit effective address. Direct forms (zero page, indexed zero page, absolute, indexed absolute, branch-relative) are resolved in a single cycle from the inputs alone. Pointer forms fetch a two-byte little-endian address from memory through a synchronous read port, one byte per cycle, and then finish the address.

A caller pulses `start` with the inputs valid for that cycle. The unit answers with a one-cycle `done` pulse, and `ea` holds the result until the next `done`. While a pointer fetch is in flight, further `start` pulses are dropped. The memory port returns `mem_rdata` on the cycle after the cycle in which `mem_rd` and `mem_addr` were presented.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset is asserted and until the first request, `done` and `mem_rd` are 0 and `ea` is 0000h.
- R2: Mode code 0 (zero page) gives `ea` = {00h, op_lo}; any direct mode (codes 0–6 and 12–15) raises `done` in the cycle after `start` is sampled, with no memory read.
- R3: Codes 1 (zero page + X) and 2 (zero page + Y) give `ea` = {00h, (op_lo + index) mod 256}; the carry is dropped.
- R4: Code 3 gives {op_hi, op_lo}; codes 4 (+X) and 5 (+Y) add the zero-extended index to {op_hi, op_lo} modulo 65536, carrying into the high byte. Unused codes 12–15 act like code 3.
- R5: Code 6 (relative) gives `next_pc` plus op_lo taken as a signed byte (−128..+127), modulo 65536.
- R6: Code 7 ((zp,X)) reads the low byte at zero-page address (op_lo + X) mod 256 and the high byte at the next zero-page address, wrapping FFh to 00h; `ea` is that pointer.
- R7: Code 8 ((zp),Y) reads a pointer at zero-page op_lo and op_lo+1 (wrapping inside page 0) and adds Y to it with the carry going into the high byte.
- R8: Code 9 ((zp)) reads the pointer at zero-page op_lo and op_lo+1 (wrapping inside page 0) and returns it unchanged.
- R9: Code 10 ((abs), jumps) reads the pointer at {op_hi, op_lo} and the following 16-bit address; code 11 ((abs,X), jumps) first adds X to {op_hi, op_lo} with full 16-bit carry.
- R10: Pointer modes issue exactly two reads on consecutive cycles, low byte first, starting the cycle after `start` is sampled; `done` rises the cycle after the last read cycle's data has been taken, four cycles after the `start` edge.
- R11: `done` lasts one cycle and `ea` stays unchanged until the next `done`.
- R12: A `start` pulse sampled while a pointer fetch is in progress is ignored: the pending result and its timing are unaffected and no extra `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe, sampled with the other request inputs |
| mode | input | 4 | Addressing-mode code (see requirements) |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| next_pc | input | 16 | Address of the following instruction |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| ea | output | 16 | Effective address |
| done | output | 1 | One-cycle result strobe |

## Verification
The assertions watch the pointer fetch on every cycle: reads come in pairs on back-to-back cycles, the second address is one above the first in its low byte and stays in page 0 for zero-page pointer forms, `done` follows the end of a read pair and is never a two-cycle pulse. The arithmetic of each mode (index carries, signed branch offsets, Y added after the fetch) and the dropping of requests during a fetch can only be shown by the bench, which compares `ea` and the latency against a model over random and corner-case requests.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int MW = 4;

  typedef enum logic [MW-1:0] {
    AM_ZP   = 4'd0,
    AM_ZPX  = 4'd1,
    AM_ZPY  = 4'd2,
    AM_ABS  = 4'd3,
    AM_ABSX = 4'd4,
    AM_ABSY = 4'd5,
    AM_REL  = 4'd6,
    AM_IZX  = 4'd7,
    AM_IZY  = 4'd8,
    AM_IZP  = 4'd9,
    AM_IND  = 4'd10,
    AM_IAX  = 4'd11
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RDLO = 2'd1,
    SQ_RDHI = 2'd2,
    SQ_JOIN = 2'd3
  } seq_state_e;

  function automatic logic mode_uses_ptr(input logic [MW-1:0] m);
    return (m == AM_IZX) || (m == AM_IZY) || (m == AM_IZP) ||
           (m == AM_IND) || (m == AM_IAX);
  endfunction
endpackage

// File: rtl/eag_direct.sv
module eag_direct
  import eag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [MW-1:0]   mode,
  input  logic [DW-1:0]   op_lo,
  input  logic [DW-1:0]   op_hi,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  input  logic [2*DW-1:0] next_pc,
  output logic [2*DW-1:0] direct_ea,
  output logic [2*DW-1:0] ptr_base,
  output logic            ptr_zp,
  output logic            ptr_add_y
);
  localparam int AW = 2 * DW;

  logic [DW-1:0] zp_plus_x;
  logic [DW-1:0] zp_plus_y;
  logic [AW-1:0] abs_base;
  logic [AW-1:0] rel_off;

  always_comb begin
    zp_plus_x = op_lo + idx_x;
    zp_plus_y = op_lo + idx_y;
    abs_base  = {op_hi, op_lo};
    rel_off   = {{DW{op_lo[DW-1]}}, op_lo};
  end

  always_comb begin
    case (mode)
      AM_ZP:   direct_ea = {{DW{1'b0}}, op_lo};
      AM_ZPX:  direct_ea = {{DW{1'b0}}, zp_plus_x};
      AM_ZPY:  direct_ea = {{DW{1'b0}}, zp_plus_y};
      AM_ABSX: direct_ea = abs_base + {{DW{1'b0}}, idx_x};
      AM_ABSY: direct_ea = abs_base + {{DW{1'b0}}, idx_y};
      AM_REL:  direct_ea = next_pc + rel_off;
      default: direct_ea = abs_base;
    endcase
  end

  always_comb begin
    ptr_zp    = 1'b0;
    ptr_add_y = 1'b0;
    case (mode)
      AM_IZX: begin
        ptr_base = {{DW{1'b0}}, zp_plus_x};
        ptr_zp   = 1'b1;
      end
      AM_IZY: begin
        ptr_base  = {{DW{1'b0}}, op_lo};
        ptr_zp    = 1'b1;
        ptr_add_y = 1'b1;
      end
      AM_IZP: begin
        ptr_base = {{DW{1'b0}}, op_lo};
        ptr_zp   = 1'b1;
      end
      AM_IAX:  ptr_base = abs_base + {{DW{1'b0}}, idx_x};
      default: ptr_base = abs_base;
    endcase
  end
endmodule

// File: rtl/eag_ptr_seq.sv
module eag_ptr_seq
  import eag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [2*DW-1:0] ptr_base,
  input  logic            ptr_zp,
  input  logic            ptr_add_y,
  input  logic [DW-1:0]   idx_y,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_rd,
  output logic [2*DW-1:0] mem_addr,
  output logic            busy,
  output logic            wrap_act,
  output logic            fin_valid,
  output logic [2*DW-1:0] fin_ea
);
  localparam int AW = 2 * DW;

  seq_state_e    state_q, state_d;
  logic [AW-1:0] ptr_q;
  logic          zp_q;
  logic          addy_q;
  logic [DW-1:0] y_q;
  logic [DW-1:0] lo_q;
  logic          cap_req;
  logic          cap_lo;
  logic [DW-1:0] ptr_lo_inc;
  logic [AW-1:0] hi_addr;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE: if (launch) state_d = SQ_RDLO;
      SQ_RDLO: state_d = SQ_RDHI;
      SQ_RDHI: state_d = SQ_JOIN;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    cap_req    = (state_q == SQ_IDLE) && launch;
    cap_lo     = (state_q == SQ_RDHI);
    ptr_lo_inc = ptr_q[DW-1:0] + 1'b1;
    hi_addr    = zp_q ? {{DW{1'b0}}, ptr_lo_inc} : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      zp_q   <= 1'b0;
      addy_q <= 1'b0;
      y_q    <= '0;
    end else if (cap_req) begin
      ptr_q  <= ptr_base;
      zp_q   <= ptr_zp;
      addy_q <= ptr_add_y;
      y_q    <= idx_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (cap_lo) begin
      lo_q <= mem_rdata;
    end
  end

  always_comb begin
    mem_rd    = (state_q == SQ_RDLO) || (state_q == SQ_RDHI);
    mem_addr  = (state_q == SQ_RDHI) ? hi_addr : ptr_q;
    busy      = (state_q != SQ_IDLE);
    wrap_act  = zp_q;
    fin_valid = (state_q == SQ_JOIN);
    fin_ea    = {mem_rdata, lo_q} + (addy_q ? {{DW{1'b0}}, y_q} : {AW{1'b0}});
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MW-1:0]   mode,
  input  logic [DW-1:0]   op_lo,
  input  logic [DW-1:0]   op_hi,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  input  logic [2*DW-1:0] next_pc,
  output logic            mem_rd,
  output logic [2*DW-1:0] mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] ea,
  output logic            done
);
  localparam int AW    = 2 * DW;
  localparam int SYNC  = 2;

  logic [SYNC-1:0] rst_pipe;
  logic            rst_sync_n;
  logic [AW-1:0]   direct_ea;
  logic [AW-1:0]   ptr_base;
  logic            ptr_zp;
  logic            ptr_add_y;
  logic            busy;
  logic            seq_wrap;
  logic            fin_valid;
  logic [AW-1:0]   fin_ea;
  logic            accept;
  logic            go_ptr;
  logic            go_direct;
  logic [AW-1:0]   ea_q, ea_d;
  logic            done_q, done_d;
  logic            ea_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC-1];

  eag_direct #(.DW(DW)) u_direct (
    .mode      (mode),
    .op_lo     (op_lo),
    .op_hi     (op_hi),
    .idx_x     (idx_x),
    .idx_y     (idx_y),
    .next_pc   (next_pc),
    .direct_ea (direct_ea),
    .ptr_base  (ptr_base),
    .ptr_zp    (ptr_zp),
    .ptr_add_y (ptr_add_y)
  );

  always_comb begin
    accept    = start && !busy;
    go_ptr    = accept && mode_uses_ptr(mode);
    go_direct = accept && !mode_uses_ptr(mode);
  end

  eag_ptr_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch    (go_ptr),
    .ptr_base  (ptr_base),
    .ptr_zp    (ptr_zp),
    .ptr_add_y (ptr_add_y),
    .idx_y     (idx_y),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .wrap_act  (seq_wrap),
    .fin_valid (fin_valid),
    .fin_ea    (fin_ea)
  );

  always_comb begin
    ea_en  = go_direct || fin_valid;
    ea_d   = fin_valid ? fin_ea : direct_ea;
    done_d = ea_en;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ea_q <= '0;
    end else if (ea_en) begin
      ea_q <= ea_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign ea   = ea_q;
  assign done = done_q;
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          seq_wrap
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_read_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |=> mem_rd);

  assert_read_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |=> !mem_rd);

  assert_done_after_reads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd) |=> done);

  assert_no_read_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && done));

  assert_next_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) + 1'b1));

  assert_zp_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd) && seq_wrap) |-> (mem_addr[AW-1:DW] == '0));
endmodule

bind eff_addr_gen eag_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .done     (done),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .seq_wrap (seq_wrap)
);

// File: tb/test_eff_addr_gen.sv
`timescale 1ns/1ps
module test_eff_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  mode;
  logic [7:0]  op_lo, op_hi, idx_x, idx_y;
  logic [15:0] next_pc;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [15:0] ea;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #5 clk = ~clk;

  eff_addr_gen i_eff_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y),
    .next_pc(next_pc), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .ea(ea), .done(done)
  );

  function automatic logic [7:0] mem_of(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_of(mem_addr);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic bit is_ptr(input logic [3:0] m);
    return (m >= 4'd7) && (m <= 4'd11);
  endfunction

  function automatic logic [15:0] exp_ea(input logic [3:0] m, input logic [7:0] lo,
      input logic [7:0] hi, input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc);
    logic [7:0]  z;
    logic [15:0] p, p2, v;
    case (m)
      4'd0: return {8'h00, lo};
      4'd1: begin z = lo + x; return {8'h00, z}; end
      4'd2: begin z = lo + y; return {8'h00, z}; end
      4'd4: return {hi, lo} + {8'h00, x};
      4'd5: return {hi, lo} + {8'h00, y};
      4'd6: return pc + {{8{lo[7]}}, lo};
      4'd7, 4'd8, 4'd9: begin
        z = (m == 4'd7) ? lo + x : lo;
        p = {8'h00, z};
        z = z + 8'd1;
        p2 = {8'h00, z};
        v = {mem_of(p2), mem_of(p)};
        return (m == 4'd8) ? v + {8'h00, y} : v;
      end
      4'd10, 4'd11: begin
        p  = (m == 4'd11) ? {hi, lo} + {8'h00, x} : {hi, lo};
        p2 = p + 16'd1;
        return {mem_of(p2), mem_of(p)};
      end
      default: return {hi, lo};
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      4'd10, 4'd11: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // poke: issue a second start during a pointer fetch (R12)
  task automatic run_one(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
      input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc, input bit poke);
    logic [15:0] e;
    int lat, exp_lat, extra;
    e = exp_ea(m, lo, hi, x, y, pc);
    exp_lat = is_ptr(m) ? 4 : 1;
    @(negedge clk);
    mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; next_pc = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (poke && is_ptr(m)) begin
      mode = 4'd0; op_lo = ~lo; start = 1'b1;
    end
    while (!done && lat < 12) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk(ea == e, req_of(m), {16'h0, ea}, {16'h0, e});
    chk(lat == exp_lat, is_ptr(m) ? "R10" : "R2", lat, exp_lat);
    @(negedge clk);
    chk(!done && ea == e, "R11", {15'h0, done, ea}, {16'h0, e});
    if (poke) begin
      extra = 0;
      repeat (3) begin @(negedge clk); if (done) extra++; end
      chk(extra == 0 && ea == e, "R12", extra, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; mode = '0; op_lo = '0; op_hi = '0;
    idx_x = '0; idx_y = '0; next_pc = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_rd == 1'b0 && ea == 16'h0, "R1", {14'h0, done, mem_rd, ea}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && ea == 16'h0, "R1", {15'h0, done, ea}, 0);

    run_one(4'd0, 8'h3C, 8'h99, 8'h00, 8'h00, 16'h0000, 0); // R2
    run_one(4'd1, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0000, 0); // R3 wrap
    run_one(4'd2, 8'hFF, 8'h12, 8'h00, 8'h01, 16'h0000, 0); // R3 wrap
    run_one(4'd4, 8'hFF, 8'hFF, 8'h02, 8'h00, 16'h0000, 0); // R4 wrap FFFF
    run_one(4'd5, 8'hF0, 8'h12, 8'h00, 8'h20, 16'h0000, 0); // R4 carry
    run_one(4'd13, 8'h34, 8'h12, 8'h55, 8'h66, 16'h0000, 0); // R4 unused code
    run_one(4'd6, 8'h80, 8'h00, 8'h00, 8'h00, 16'h1000, 0); // R5 -128
    run_one(4'd6, 8'h7F, 8'h00, 8'h00, 8'h00, 16'hFFF0, 0); // R5 wrap
    run_one(4'd7, 8'hF0, 8'h00, 8'h0F, 8'h00, 16'h0000, 0); // R6 ptr at FF
    run_one(4'd8, 8'hFF, 8'h00, 8'h00, 8'hFF, 16'h0000, 0); // R7 wrap + carry
    run_one(4'd9, 8'hFF, 8'h77, 8'h00, 8'h00, 16'h0000, 0); // R8 wrap
    run_one(4'd10, 8'hFF, 8'h00, 8'h00, 8'h00, 16'h0000, 0); // R9 crosses page
    run_one(4'd11, 8'hFE, 8'h12, 8'h01, 8'h00, 16'h0000, 0); // R9 indexed
    run_one(4'd8, 8'h40, 8'h00, 8'h00, 8'h10, 16'h0000, 1); // R12

    for (int i = 0; i < 400; i++) begin
      run_one(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 16'($urandom), bit'($urandom_range(0, 1)));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule